// File: doc/BRIEF.md
# Selectable Pin Event Detector

This block watches a parallel bank of asynchronous input pins and holds a single pending-event flag. Software-side logic writes a selector word that names one pin and the condition to watch for on it. When that condition is seen on the synchronized pin, the flag sets and stays set until an acknowledge arrives. The flag is a registered output, so a controller can stall on it directly.

There are two kinds of condition. Edge conditions are rising, falling, or any change, and each transition fires once. Level conditions are low or high. A level condition re-arms at once: while the level still holds, an acknowledge cannot drop the flag. A consumer that waits on a level has to wait for the level to go away before it acknowledges. Every pin passes through a multi-flop synchronizer before any comparison is made. Loading a new selector discards any pending event and takes a fresh reference sample, so the reconfiguration itself cannot produce an edge.

Top module: `pinevt_trigger`

## Requirements
- R1: After synchronous reset, `evt_pending` is 0 and the detector is disabled (mode 000).
- R2: The selector is 9 bits. Bits 8:6 hold the mode and bits 5:0 hold the pin index. Activity on pins other than the indexed one never affects the flag.
- R3: Mode 001 sets the flag on a low-to-high transition of the selected pin. A high-to-low transition does not set it.
- R4: Mode 010 sets the flag on a high-to-low transition. A selector of 0x80 plus the pin index therefore waits for a falling edge, and a rising edge or a steady high level does not set the flag.
- R5: Mode 011 sets the flag on any transition of the selected pin.
- R6: Modes 100 and 101 set the flag while the pin is low. Modes 110 and 111 set it while the pin is high. Bit 6 has no effect in level modes.
- R7: In a level mode, an acknowledge given while the level still holds leaves `evt_pending` at 1. Once the level has gone away, an acknowledge clears it.
- R8: Mode 000 never sets the flag, whatever the pins do.
- R9: Once set, the flag stays at 1 until an acknowledge or a selector write.
- R10: A selector write clears the flag in the next cycle. A selector write never by itself causes an edge: selecting rising mode on a pin that is already high does not fire.
- R11: When an acknowledge and a qualifying event fall in the same cycle, the event wins and the flag stays at 1.
- R12: A pin change applied before a rising clock edge shows on `evt_pending` after the third rising edge: two synchronizer stages and then the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | NUM_PINS (64) | Asynchronous pin bank |
| cfg_we | input | 1 | Selector write strobe |
| cfg_sel | input | 9 | Selector word: mode in bits 8:6, pin index in bits 5:0 |
| ack | input | 1 | Acknowledge; clears the pending flag |
| evt_pending | output | 1 | Registered pending-event flag |

## Verification
The bench targets these corner cases:

- **Falling-edge selector 0x80 plus pin.** A design that decoded it as a high level would fire on a steady high pin.
- **Rising mode on a pin already high at configuration.** If the reference sample is not reloaded on the write, a stale sample produces a false edge.
- **Acknowledge against a held level.** A design that lets the acknowledge win would show a one-cycle drop.
- **Acknowledge in the same cycle as a new edge.** A design that lets the acknowledge win here loses the event.
- **Latency.** The output is sampled one edge before and at the expected edge, so an extra or missing synchronizer stage is caught.
- **Unselected pins.** All of them are toggled to catch a wrong index decode.

// File: rtl/pinevt_pkg.sv
package pinevt_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_OFF    = 3'b000,
    MD_RISE   = 3'b001,
    MD_FALL   = 3'b010,
    MD_CHANGE = 3'b011,
    MD_LOW_A  = 3'b100,
    MD_LOW_B  = 3'b101,
    MD_HIGH_A = 3'b110,
    MD_HIGH_B = 3'b111
  } evt_mode_e;

  // Level modes are those with the top mode bit set.
  function automatic logic mode_is_level(input logic [MODE_W-1:0] m);
    return m[MODE_W-1];
  endfunction

endpackage

// File: rtl/pinevt_sync.sv
module pinevt_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/pinevt_pick.sv
module pinevt_pick #(
  parameter int NUM_PINS = 64,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic [NUM_PINS-1:0] bits,
  input  logic [IDX_W-1:0]    idx,
  output logic                bit_out
);

  localparam int PADDED = 1 << IDX_W;

  logic [PADDED-1:0] padded;

  generate
    if (PADDED > NUM_PINS) begin : g_pad
      assign padded = {{(PADDED-NUM_PINS){1'b0}}, bits};
    end else begin : g_exact
      assign padded = bits;
    end
  endgenerate

  assign bit_out = padded[idx];

endmodule

// File: rtl/pinevt_cond.sv
module pinevt_cond
  import pinevt_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              cur,
  input  logic              prev,
  output logic              hit
);

  always_comb begin
    case (evt_mode_e'(mode))
      MD_RISE:             hit = cur & ~prev;
      MD_FALL:             hit = ~cur & prev;
      MD_CHANGE:           hit = cur ^ prev;
      MD_LOW_A, MD_LOW_B:   hit = ~cur;
      MD_HIGH_A, MD_HIGH_B: hit = cur;
      default:             hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pinevt_flag.sv
module pinevt_flag (
  input  logic clk,
  input  logic rst,
  input  logic clr_cfg,
  input  logic hit,
  input  logic ack,
  output logic flag
);

  // Priority: selector write, then event, then acknowledge.
  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (clr_cfg) flag <= 1'b0;
    else if (hit)     flag <= 1'b1;
    else if (ack)     flag <= 1'b0;
  end

endmodule

// File: rtl/pinevt_trigger.sv
module pinevt_trigger
  import pinevt_pkg::*;
#(
  parameter int NUM_PINS    = 64,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = $clog2(NUM_PINS),
  parameter int SEL_W       = MODE_W + IDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins_in,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic                ack,
  output logic                evt_pending
);

  logic [NUM_PINS-1:0] pins_s;
  logic [SEL_W-1:0]    sel_q;
  logic                cur_bit;
  logic                new_bit;
  logic                prev_q;
  logic                hit;

  pinevt_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pins_in),
    .q_sync  (pins_s)
  );

  // Sample of the currently selected pin.
  pinevt_pick #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_pick_cur (
    .bits    (pins_s),
    .idx     (sel_q[IDX_W-1:0]),
    .bit_out (cur_bit)
  );

  // Sample of the pin being selected by a write in progress.
  pinevt_pick #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_pick_new (
    .bits    (pins_s),
    .idx     (cfg_sel[IDX_W-1:0]),
    .bit_out (new_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      prev_q <= 1'b0;
    end else if (cfg_we) begin
      sel_q  <= cfg_sel;
      prev_q <= new_bit;
    end else begin
      prev_q <= cur_bit;
    end
  end

  pinevt_cond u_cond (
    .mode (sel_q[SEL_W-1 -: MODE_W]),
    .cur  (cur_bit),
    .prev (prev_q),
    .hit  (hit)
  );

  pinevt_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .clr_cfg (cfg_we),
    .hit     (hit),
    .ack     (ack),
    .flag    (evt_pending)
  );

endmodule

// File: rtl/pinevt_trigger_chk.sv
module pinevt_trigger_chk #(
  parameter int SEL_W  = 9,
  parameter int MODE_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [SEL_W-1:0] cfg_sel,
  input logic             ack,
  input logic             evt_pending
);

  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= '0;
    else if (cfg_we) mode_q <= cfg_sel[SEL_W-1 -: MODE_W];
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> !evt_pending);

  a_r10_cfg_clears: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> !evt_pending);

  a_r8_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_q == '0) |-> !evt_pending);

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (evt_pending && !ack && !cfg_we) |=> evt_pending);

  a_r10_no_set_on_write: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_pending) |-> !$past(cfg_we));

endmodule

bind pinevt_trigger pinevt_trigger_chk #(.SEL_W(SEL_W), .MODE_W(3)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .ack         (ack),
  .evt_pending (evt_pending)
);

// File: tb/pinevt_trigger_tb.sv
module pinevt_trigger_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NPINS      = 64;
  localparam logic [63:0] BG = 64'h0F0F_3C3C_5A5A_9696;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NPINS-1:0] pins = '0;
  logic             cfg_we = 1'b0;
  logic [8:0]       cfg_sel = '0;
  logic             ack = 1'b0;
  logic             evt_pending;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinevt_trigger u_dut (
    .clk         (clk),
    .rst         (rst),
    .pins_in     (pins),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .ack         (ack),
    .evt_pending (evt_pending)
  );

  // Entry: [16:13] tag, [12:10] mode, [9:4] pin, [3] start, [2] end, [1] pre, [0] post
  localparam int NVEC = 13;
  localparam logic [16:0] VEC [NVEC] = '{
    {4'd3,  3'b001, 6'd5,  1'b0, 1'b1, 1'b0, 1'b1},
    {4'd3,  3'b001, 6'd5,  1'b1, 1'b0, 1'b0, 1'b0},
    {4'd4,  3'b010, 6'd0,  1'b1, 1'b0, 1'b0, 1'b1},
    {4'd4,  3'b010, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0},
    {4'd5,  3'b011, 6'd63, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'd5,  3'b011, 6'd63, 1'b1, 1'b0, 1'b0, 1'b1},
    {4'd6,  3'b100, 6'd17, 1'b1, 1'b0, 1'b0, 1'b1},
    {4'd6,  3'b101, 6'd17, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd6,  3'b110, 6'd40, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'd6,  3'b111, 6'd40, 1'b1, 1'b1, 1'b1, 1'b1},
    {4'd8,  3'b000, 6'd9,  1'b0, 1'b1, 1'b0, 1'b0},
    {4'd8,  3'b000, 6'd9,  1'b1, 1'b0, 1'b0, 1'b0},
    {4'd10, 3'b001, 6'd33, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd8:    return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic configure(input logic [2:0] mode, input logic [5:0] idx);
    cfg_sel = {mode, idx};
    cfg_we  = 1'b1;
    cyc(1);
    cfg_we  = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    check("R1", evt_pending, 1'b0, "flag after reset");
    pins = '1;
    cyc(5);
    check("R1", evt_pending, 1'b0, "disabled after reset with pins high");

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [16:0] e;
      e = VEC[i];
      pins = BG;
      pins[e[9:4]] = e[3];
      cyc(4);
      configure(e[12:10], e[9:4]);
      cyc(4);
      check(tag_name(e[16:13]), evt_pending, e[1], $sformatf("vec %0d before change", i));
      pins[e[9:4]] = e[2];
      cyc(4);
      check(tag_name(e[16:13]), evt_pending, e[0], $sformatf("vec %0d after change", i));
    end

    // R2: only the indexed pin matters
    pins = BG;
    pins[12] = 1'b0;
    cyc(4);
    configure(3'b001, 6'd12);
    pins = ~pins;
    pins[12] = 1'b0;
    cyc(4);
    check("R2", evt_pending, 1'b0, "other pins toggled");
    pins[12] = 1'b1;
    cyc(4);
    check("R2", evt_pending, 1'b1, "indexed pin rose");

    // R9: sticky until acknowledge
    pins[12] = 1'b0;
    cyc(6);
    check("R9", evt_pending, 1'b1, "held after pin returned");
    pulse_ack();
    check("R9", evt_pending, 1'b0, "cleared by ack");

    // R12: latency
    cyc(2);
    pins[12] = 1'b1;
    cyc(2);
    check("R12", evt_pending, 1'b0, "after two edges");
    cyc(1);
    check("R12", evt_pending, 1'b1, "after three edges");

    // R10: write clears pending
    configure(3'b000, 6'd12);
    check("R10", evt_pending, 1'b0, "write clears flag");

    // R7: level re-fire
    pins[3] = 1'b1;
    cyc(4);
    configure(3'b110, 6'd3);
    cyc(2);
    check("R7", evt_pending, 1'b1, "high level pending");
    pulse_ack();
    check("R7", evt_pending, 1'b1, "ack while level held");
    pins[3] = 1'b0;
    cyc(4);
    pulse_ack();
    check("R7", evt_pending, 1'b0, "ack after level gone");

    // R11: event beats coincident acknowledge
    pins[7] = 1'b0;
    cyc(4);
    configure(3'b011, 6'd7);
    pins[7] = 1'b1;
    cyc(3);
    check("R11", evt_pending, 1'b1, "first change set");
    pins[7] = 1'b0;
    cyc(2);
    pulse_ack();
    check("R11", evt_pending, 1'b1, "ack with same-cycle event");
    pulse_ack();
    check("R11", evt_pending, 1'b0, "ack without event");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule